// File: doc/BRIEF.md
# UART Receiver with Control Registers

This block receives asynchronous serial frames on a single input line and hands them to software through a small register bus. A frame has a low start bit, eight or nine data bits sent least significant bit first, and a high stop bit. The bit rate comes from an 8-bit divisor and a rate-select bit. A two-entry receive queue holds finished frames. Each entry carries the byte, the ninth bit and the framing result of its frame.

Software first reads the status register. It shows the ninth bit and the framing result of the oldest frame, the sticky overrun flag and the data-ready flag. Software then reads the data register, and that read removes the frame from the queue. A registered interrupt output is high while data is waiting and all three enable levels are set. The address-detect control bit is stored and reads back, but it has no effect on reception.

Top module: `uart_rx_regs`

Register map (byte-wide, `regAddr`):
- 0 control: bit0 port enable, bit1 synchronous-mode select, bit2 receive enable, bit3 nine-bit frames, bit4 address-detect (stored only), bit5 high-speed rate.
- 1 status (read only): bit0 ninth bit of oldest frame, bit1 framing error of oldest frame, bit2 overrun, bit3 data ready.
- 2 data (read pops the queue).
- 3 baud divisor N.
- 4 interrupt enables: bit0 receive, bit1 peripheral, bit2 global.
- Other addresses read 0. Writes to status and data are ignored.

## Requirements
- R1: After reset every register reads 0, including the status register, and `irq` is 0.
- R2: The control, divisor and interrupt-enable registers read back the written value in the bit positions of the map. Setting address-detect (control bit4) does not change what is received.
- R3: Frames are received only while port enable is 1, synchronous select is 0 and receive enable is 1. A frame sent in any other setting leaves status at 0.
- R4: The line is sampled once every N+1 clocks. A bit lasts 16 samples when high-speed is 0 and 4 samples when it is 1. Frames at that bit time are received correctly for every N and both rate settings.
- R5: Each bit value is the majority of three consecutive samples, the last one at the middle sample of the bit. A start bit that is not low by that vote is dropped. A one-clock glitch inside a bit is outvoted.
- R6: In eight-bit mode the byte appears in the data register, and status bit0 reads 0.
- R7: In nine-bit mode the first eight data bits appear in the data register and the ninth bit appears in status bit0.
- R8: A frame whose stop bit votes low is still stored, and its status bit1 reads 1. The next good frame shows bit1 as 0.
- R9: The queue holds two frames in arrival order. Status bit3 is 1 while the queue is not empty. Each data read removes the oldest frame.
- R10: A frame that completes while both entries are full sets overrun (status bit2) and is dropped. No further frame is stored while overrun is set.
- R11: Reads do not clear overrun. Writing receive enable to 0 clears it, and reception resumes when receive enable is set again.
- R12: `irq` is 1 one clock after data-ready, receive enable, peripheral enable and global enable are all 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Register read strobe (pops the queue at the data address) |
| regRdData | output | 8 | Read data, combinational from `regAddr` |
| rxIn | input | 1 | Serial receive line, idle high |
| irq | output | 1 | Receive interrupt |

## Verification
The assertions check several rules on every cycle. They check that the receive state machine returns to idle when reception is disabled, that the queue never exceeds its depth, and that it never grows while overrun is set. They also check that overrun is cleared whenever receive enable is low, and that the interrupt rises only after global enable and queued data were present. Correct bit timing at every divisor and rate, majority voting against glitches, where the ninth bit and the framing bit land, and queue ordering across overrun can only be shown by the bench's frame sweeps. The bench compares what it sent with what the registers return.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic baudRestart;
    logic shiftIn;
    logic frameDone;
    logic frameErr;
  } rxStrobe_t;

  typedef struct packed {
    logic [7:0] data;
    logic       ninth;
    logic       ferr;
  } rxEntry_t;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_DATA = 2;
  localparam int ADDR_DIV  = 3;
  localparam int ADDR_IEN  = 4;

  localparam int CB_PORT  = 0;
  localparam int CB_SYNC  = 1;
  localparam int CB_RXEN  = 2;
  localparam int CB_NINE  = 3;
  localparam int CB_ADET  = 4;
  localparam int CB_HSPD  = 5;

  localparam int IB_RX    = 0;
  localparam int IB_PER   = 1;
  localparam int IB_GLB   = 2;

endpackage

// File: rtl/uart_rx_control.sv
module uart_rx_control
  import uart_rx_pkg::*;
#(
  parameter int OSR_LO = 16,
  parameter int OSR_HI = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      active,
  input  logic      nineBit,
  input  logic      highSpeed,
  input  logic      tick,
  input  logic      rxLine,
  input  logic      vote,
  output rxStrobe_t strobe
);

  localparam int CNT_W = $clog2(OSR_LO);
  localparam logic [CNT_W-1:0] EVAL_LO = CNT_W'(OSR_LO / 2);
  localparam logic [CNT_W-1:0] EVAL_HI = CNT_W'(OSR_HI / 2);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(OSR_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(OSR_HI - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [3:0]       bitCnt;

  logic [CNT_W-1:0] evalIdx;
  logic [CNT_W-1:0] lastIdx;
  logic [3:0]       lastData;
  logic             atEval;
  logic             atLast;

  assign evalIdx  = highSpeed ? EVAL_HI : EVAL_LO;
  assign lastIdx  = highSpeed ? LAST_HI : LAST_LO;
  assign lastData = nineBit ? 4'd8 : 4'd7;
  assign atEval   = tick && (tickCnt == evalIdx);
  assign atLast   = tick && (tickCnt == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (!active) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!rxLine) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (tick) tickCnt <= atLast ? '0 : tickCnt + 1'b1;
          if (atEval && vote) state <= ST_IDLE;
          else if (atLast) begin
            state  <= ST_DATA;
            bitCnt <= '0;
          end
        end
        ST_DATA: begin
          if (tick) tickCnt <= atLast ? '0 : tickCnt + 1'b1;
          if (atLast) begin
            if (bitCnt == lastData) state <= ST_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tick) tickCnt <= atLast ? '0 : tickCnt + 1'b1;
          if (atEval) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.baudRestart = active && (state == ST_IDLE) && !rxLine;
    strobe.shiftIn     = active && (state == ST_DATA) && atEval;
    strobe.frameDone   = active && (state == ST_STOP) && atEval;
    strobe.frameErr    = !vote;
  end

  // R3: receiver parks in idle while reception is disabled
  a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> state == ST_IDLE);

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              regRdEn,
  output logic [7:0]        regRdData,
  input  logic              rxIn,
  output logic              irq,
  input  rxStrobe_t         strobe,
  output logic              tick,
  output logic              rxLine,
  output logic              vote,
  output logic              active,
  output logic              nineBit,
  output logic              highSpeed
);

  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(FIFO_DEPTH - 1);

  // control and enable registers
  logic portEn, syncSel, rxEn, addrDet;
  logic rxIe, perIe, glbIe;
  logic [DIV_W-1:0] divReg;

  logic wrCtrl, wrDiv, wrIen, rdData;
  assign wrCtrl = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
  assign wrDiv  = regWrEn && (regAddr == ADDR_W'(ADDR_DIV));
  assign wrIen  = regWrEn && (regAddr == ADDR_W'(ADDR_IEN));
  assign rdData = regRdEn && (regAddr == ADDR_W'(ADDR_DATA));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portEn    <= 1'b0;
      syncSel   <= 1'b0;
      rxEn      <= 1'b0;
      nineBit   <= 1'b0;
      addrDet   <= 1'b0;
      highSpeed <= 1'b0;
      divReg    <= '0;
      rxIe      <= 1'b0;
      perIe     <= 1'b0;
      glbIe     <= 1'b0;
    end else begin
      if (wrCtrl) begin
        portEn    <= regWrData[CB_PORT];
        syncSel   <= regWrData[CB_SYNC];
        rxEn      <= regWrData[CB_RXEN];
        nineBit   <= regWrData[CB_NINE];
        addrDet   <= regWrData[CB_ADET];
        highSpeed <= regWrData[CB_HSPD];
      end
      if (wrDiv) divReg <= regWrData[DIV_W-1:0];
      if (wrIen) begin
        rxIe  <= regWrData[IB_RX];
        perIe <= regWrData[IB_PER];
        glbIe <= regWrData[IB_GLB];
      end
    end
  end

  assign active = portEn && !syncSel && rxEn;

  // line synchronizer
  logic rxMeta;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxLine <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxLine <= rxMeta;
    end
  end

  // sample-rate prescaler
  logic [DIV_W-1:0] divCnt;
  assign tick = (divCnt >= divReg);
  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (strobe.baudRestart || tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  // three-sample majority
  logic [1:0] win;
  always_ff @(posedge clk) begin
    if (!rstN) win <= 2'b11;
    else if (tick) win <= {win[0], rxLine};
  end
  assign vote = (win[1] & win[0]) | (win[1] & rxLine) | (win[0] & rxLine);

  // data shifter, LSB first into the top
  logic [8:0] shReg;
  always_ff @(posedge clk) begin
    if (!rstN) shReg <= '0;
    else if (strobe.shiftIn) shReg <= {vote, shReg[8:1]};
  end

  rxEntry_t newEntry;
  always_comb begin
    newEntry.data  = nineBit ? shReg[7:0] : shReg[8:1];
    newEntry.ninth = nineBit & shReg[8];
    newEntry.ferr  = strobe.frameErr;
  end

  // receive queue
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             overrun;
  logic             notEmpty, full, pop, push, setOvr;
  rxEntry_t         mem [FIFO_DEPTH];

  assign notEmpty = (count != '0);
  assign full     = (count == FULL_CNT);
  assign pop      = rdData && notEmpty;
  assign push     = strobe.frameDone && !overrun && !(full && !pop);
  assign setOvr   = strobe.frameDone && !overrun && full && !pop;

  for (genvar i = 0; i < FIFO_DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) mem[i] <= '0;
      else if (push && (wrPtr == PTR_W'(i))) mem[i] <= newEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      if (push && !pop) count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) overrun <= 1'b0;
    else if (!rxEn) overrun <= 1'b0;
    else if (setOvr) overrun <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else irq <= notEmpty && rxIe && perIe && glbIe;
  end

  // read mux
  rxEntry_t head;
  assign head = notEmpty ? mem[rdPtr] : '0;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_CTRL): regRdData = {2'b00, highSpeed, addrDet, nineBit, rxEn, syncSel, portEn};
      ADDR_W'(ADDR_STAT): regRdData = {4'b0000, notEmpty, overrun, head.ferr, head.ninth};
      ADDR_W'(ADDR_DATA): regRdData = head.data;
      ADDR_W'(ADDR_DIV):  regRdData = 8'(divReg);
      ADDR_W'(ADDR_IEN):  regRdData = {5'b00000, glbIe, perIe, rxIe};
      default:            regRdData = '0;
    endcase
  end

  // R9: queue occupancy bounded by its depth
  a_r9_fifo_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R10: while overrun is held the queue never grows
  a_r10_overrun_blocks: assert property (@(posedge clk) disable iff (!rstN)
    $past(overrun) |-> count <= $past(count));

  // R11: receive enable low clears overrun
  a_r11_overrun_clear: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !overrun);

  // R12: interrupt needs global enable and queued data in the prior cycle
  a_r12_irq_global: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(glbIe) && $past(notEmpty));

  // R12: peripheral level gates the interrupt
  a_r12_irq_periph: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(perIe) && $past(rxIe));

endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs
  import uart_rx_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 2,
  parameter int OSR_LO     = 16,
  parameter int OSR_HI     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              regRdEn,
  output logic [7:0]        regRdData,
  input  logic              rxIn,
  output logic              irq
);

  rxStrobe_t strobe;
  logic tick, rxLine, vote, active, nineBit, highSpeed;

  uart_rx_datapath #(
    .ADDR_W    (ADDR_W),
    .DIV_W     (DIV_W),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) datapath_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdEn   (regRdEn),
    .regRdData (regRdData),
    .rxIn      (rxIn),
    .irq       (irq),
    .strobe    (strobe),
    .tick      (tick),
    .rxLine    (rxLine),
    .vote      (vote),
    .active    (active),
    .nineBit   (nineBit),
    .highSpeed (highSpeed)
  );

  uart_rx_control #(
    .OSR_LO(OSR_LO),
    .OSR_HI(OSR_HI)
  ) control_i (
    .clk       (clk),
    .rstN      (rstN),
    .active    (active),
    .nineBit   (nineBit),
    .highSpeed (highSpeed),
    .tick      (tick),
    .rxLine    (rxLine),
    .vote      (vote),
    .strobe    (strobe)
  );

endmodule

// File: tb/uart_rx_regs_tb_top.sv
module uart_rx_regs_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic       rxIn = 1'b1;
  logic       irq;

  int nChk = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  uart_rx_regs dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .rxIn(rxIn), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, {8'h00, v}, {8'h00, exp});
  endtask

  // glitchBit: data bit index that gets a one-clock inversion at its centre, -1 for none
  task automatic sendFrame(input logic [8:0] val, input bit nine, input bit stopVal,
                           input int bitClk, input int glitchBit);
    int nb;
    nb = nine ? 9 : 8;
    @(negedge clk);
    rxIn = 1'b0;
    repeat (bitClk) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      for (int j = 0; j < bitClk; j++) begin
        rxIn = (b == glitchBit && j == bitClk / 2) ? ~val[b] : val[b];
        @(negedge clk);
      end
    end
    rxIn = stopVal;
    repeat (bitClk) @(negedge clk);
    rxIn = 1'b1;
    repeat (3 * bitClk + 4) @(negedge clk);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) rdChk("R1 reset reg", 3'(a), 8'h00);
    chk("R1 irq reset", {15'd0, irq}, 16'd0);

    // R2 readback
    wr(3'd0, 8'h3F); rdChk("R2 ctrl readback", 3'd0, 8'h3F);
    wr(3'd3, 8'hA5); rdChk("R2 div readback", 3'd3, 8'hA5);
    wr(3'd4, 8'h07); rdChk("R2 ien readback", 3'd4, 8'h07);
    wr(3'd4, 8'h00);

    // R4 R6 R9: full byte sweep, high-speed, N=0 (4 clocks per bit)
    wr(3'd3, 8'd0);
    wr(3'd0, 8'h25);
    for (int i = 0; i < 256; i++) begin
      sendFrame({1'b0, 8'(i)}, 1'b0, 1'b1, 4, -1);
      rdChk("R6 status ready", 3'd1, 8'h08);
      rdChk("R6 data byte", 3'd2, 8'(i));
      rdChk("R9 empty after pop", 3'd1, 8'h00);
    end

    // R4: rate sweep over both speeds and divisors 0..3
    for (int hs = 0; hs < 2; hs++) begin
      for (int d = 0; d < 4; d++) begin
        v = 8'(d * 61 + hs * 17 + 3);
        wr(3'd3, 8'(d));
        wr(3'd0, hs ? 8'h25 : 8'h05);
        sendFrame({1'b0, v}, 1'b0, 1'b1, (hs ? 4 : 16) * (d + 1), -1);
        rdChk("R4 rate status", 3'd1, 8'h08);
        rdChk("R4 rate data", 3'd2, v);
      end
    end

    // R7: nine-bit frames at low speed, N=1 (32 clocks per bit)
    wr(3'd3, 8'd1);
    wr(3'd0, 8'h0D);
    for (int i = 0; i < 16; i++) begin
      v = 8'((i * 37 + 11) & 8'hFF);
      sendFrame({1'(i), v}, 1'b1, 1'b1, 32, -1);
      rdChk("R7 ninth in status", 3'd1, 8'h08 | 8'(i & 1));
      rdChk("R7 low byte", 3'd2, v);
    end

    // R8 framing error
    wr(3'd3, 8'd0);
    wr(3'd0, 8'h25);
    sendFrame(9'h0C3, 1'b0, 1'b0, 4, -1);
    rdChk("R8 ferr status", 3'd1, 8'h0A);
    rdChk("R8 ferr data kept", 3'd2, 8'hC3);
    sendFrame(9'h03C, 1'b0, 1'b1, 4, -1);
    rdChk("R8 ferr cleared next frame", 3'd1, 8'h08);
    rdChk("R8 next data", 3'd2, 8'h3C);

    // R5 false start: one-clock low pulse
    @(negedge clk); rxIn = 1'b0; @(negedge clk); rxIn = 1'b1;
    repeat (60) @(negedge clk);
    rdChk("R5 false start dropped", 3'd1, 8'h00);

    // R5 glitch outvoted, low speed N=0
    wr(3'd0, 8'h05);
    sendFrame(9'h000, 1'b0, 1'b1, 16, 3);
    rdChk("R5 glitch status", 3'd1, 8'h08);
    rdChk("R5 glitch data", 3'd2, 8'h00);
    sendFrame(9'h0FF, 1'b0, 1'b1, 16, 6);
    rdChk("R5 glitch high data", 3'd2, 8'hFF);

    // R10 overrun
    wr(3'd0, 8'h25);
    sendFrame(9'h011, 1'b0, 1'b1, 4, -1);
    sendFrame(9'h022, 1'b0, 1'b1, 4, -1);
    sendFrame(9'h033, 1'b0, 1'b1, 4, -1);
    rdChk("R10 overrun set", 3'd1, 8'h0C);
    rdChk("R10 first kept", 3'd2, 8'h11);
    rdChk("R10 second kept", 3'd2, 8'h22);
    rdChk("R11 read keeps overrun", 3'd1, 8'h04);
    sendFrame(9'h044, 1'b0, 1'b1, 4, -1);
    rdChk("R10 frame dropped", 3'd1, 8'h04);

    // R11 clear by receive enable low
    wr(3'd0, 8'h21);
    rdChk("R11 overrun cleared", 3'd1, 8'h00);
    wr(3'd0, 8'h25);
    sendFrame(9'h055, 1'b0, 1'b1, 4, -1);
    rdChk("R11 resumed status", 3'd1, 8'h08);
    rdChk("R11 resumed data", 3'd2, 8'h55);

    // R3 disabled settings
    wr(3'd0, 8'h24);
    sendFrame(9'h099, 1'b0, 1'b1, 4, -1);
    rdChk("R3 port off ignored", 3'd1, 8'h00);
    wr(3'd0, 8'h27);
    sendFrame(9'h099, 1'b0, 1'b1, 4, -1);
    rdChk("R3 sync mode ignored", 3'd1, 8'h00);
    wr(3'd0, 8'h21);
    sendFrame(9'h099, 1'b0, 1'b1, 4, -1);
    rdChk("R3 rx off ignored", 3'd1, 8'h00);

    // R2 address-detect inert
    wr(3'd0, 8'h35);
    sendFrame(9'h077, 1'b0, 1'b1, 4, -1);
    rdChk("R2 addr detect status", 3'd1, 8'h08);
    rdChk("R2 addr detect data", 3'd2, 8'h77);

    // R12 interrupt gating
    wr(3'd0, 8'h25);
    sendFrame(9'h0AB, 1'b0, 1'b1, 4, -1);
    for (int e = 0; e < 8; e++) begin
      wr(3'd4, 8'(e));
      @(negedge clk); @(negedge clk);
      chk("R12 irq gating", {15'd0, irq}, {15'd0, e == 7});
    end
    rdChk("R12 data pop", 3'd2, 8'hAB);
    @(negedge clk); @(negedge clk);
    chk("R12 irq low when empty", {15'd0, irq}, 16'd0);

    finishRun();
  end

endmodule